// File: doc/BRIEF.md
# Runtime-Selectable Pseudo-Random Bit Pattern Source

This block produces a serial pseudo-random bit stream for exercising links and data paths. It is built on a Fibonacci linear feedback shift register. The register shifts toward its high end and the new bit enters at bit 0. A two-bit selector chooses one of four maximal-length polynomials of 5, 7, 23 or 31 stages. A polarity input chooses plain XOR feedback or its complement, XNOR. Each clock with the enable high advances the pattern by one bit.

A synchronous seed load lets a test start the pattern from a chosen point. Each length and polarity has one value from which the register can never leave, called the lock-up value. The block never enters it and, if it is ever found there, leaves it. A one-cycle wrap pulse marks each return to the starting value that was set by the last reset or configuration change. This lets a test bench frame whole periods of the pattern.

Top module: `prbs_gen`

## Requirements
- R1: Reset is synchronous and active high. It loads the default seed for the present inputs: every active bit set under XOR feedback (`xnor_fb`=0), and every bit clear under XNOR feedback (`xnor_fb`=1). After the reset edge, `prbs_bit` shows the top active bit of the state and `wrap` is 0.
- R2: With `mode`=0 (5 stages) and `en` high, each clock shifts the state one place toward bit 4. The new bit 0 is bit 4 XOR bit 2 of the old state. `prbs_bit` is the new bit 4.
- R3: The feedback pairs are bits 6 and 5 for `mode`=1 (7 stages), bits 22 and 17 for `mode`=2 (23 stages) and bits 30 and 27 for `mode`=3 (31 stages). The serial output is always the top active bit.
- R4: Starting from the default seed, the state first returns to that seed after 2^n − 1 enabled shifts (31 for 5 stages, 127 for 7 stages). `wrap` is high for exactly the one cycle in which that return shows.
- R5: Under XNOR feedback the all-zeros state is part of the sequence. The lock-up value is all active bits set.
- R6: In 5-stage XOR operation, the output stream has at most 5 ones in a row and at most 4 zeros in a row, and both lengths occur.
- R7: While `en` is low and no load, reset or configuration change is pending, the state and `prbs_bit` stay unchanged and `wrap` stays 0.
- R8: When `seed_ld` is high, the state takes `seed` masked to the active width. The load takes priority over shifting. A masked seed equal to the lock-up value (zero under XOR, all ones under XNOR) loads the default seed instead. If the state's active bits ever equal the lock-up value, the next clock loads the default seed.
- R9: A change of `mode` or `xnor_fb` between two clocks loads the default seed of the new setting on that edge. This takes priority over a seed load. The new seed also becomes the value that `wrap` compares against.
- R10: State bits above the active width are held at zero. Seed bits above the active width have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the pattern by one bit this clock |
| mode | input | 2 | Length select: 0=5, 1=7, 2=23, 3=31 stages |
| xnor_fb | input | 1 | 0 selects XOR feedback, 1 selects XNOR feedback |
| seed_ld | input | 1 | Load `seed` into the state this clock |
| seed | input | MAXW (31) | Seed value, masked to the active width |
| prbs_bit | output | 1 | Serial pattern bit, registered |
| wrap | output | 1 | One-cycle pulse on return to the start seed |

## Verification
On every cycle the assertions check four things: the state never sits at the lock-up value, the bits above the active width stay clear, the shift moves the state one place each enabled clock, and it holds still when idle. They also check that a configuration change or a lock-up-valued seed lands on the default seed, and that `wrap` never lasts two cycles. Only the bench's scenarios can show that the chosen taps give the right sequence and the full 31- and 127-cycle periods. The same is true of the run-length limits, the XNOR sequence passing through zero, and that dropped high seed bits leave the stream unchanged. These need the whole output stream compared against an independent model.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  typedef enum logic [1:0] {
    PRBS_LEN5  = 2'd0,
    PRBS_LEN7  = 2'd1,
    PRBS_LEN23 = 2'd2,
    PRBS_LEN31 = 2'd3
  } prbs_mode_e;

  // Longest register any mode needs.
  localparam int PRBS_MAX_STAGES = 31;

  // Number of stages used by a mode.
  function automatic int stages_of(prbs_mode_e m);
    case (m)
      PRBS_LEN5:  return 5;
      PRBS_LEN7:  return 7;
      PRBS_LEN23: return 23;
      default:    return 31;
    endcase
  endfunction

  // Lower feedback tap; the upper tap is always the top active stage.
  function automatic int low_tap_of(prbs_mode_e m);
    case (m)
      PRBS_LEN5:  return 2;
      PRBS_LEN7:  return 5;
      PRBS_LEN23: return 17;
      default:    return 27;
    endcase
  endfunction

endpackage

// File: rtl/prbs_tap_sel.sv
module prbs_tap_sel
  import prbs_pkg::*;
#(
  parameter int MAXW = PRBS_MAX_STAGES,
  localparam int IW = $clog2(MAXW)
) (
  input  prbs_mode_e       mode_i,
  output logic [MAXW-1:0]  mask_o,
  output logic [IW-1:0]    top_o
);

  // One mask bit per stage, set when the stage is inside the active width.
  for (genvar i = 0; i < MAXW; i++) begin : g_mask
    assign mask_o[i] = (i < stages_of(mode_i));
  end

  assign top_o = IW'(stages_of(mode_i) - 1);

endmodule

// File: rtl/prbs_lock_guard.sv
module prbs_lock_guard #(
  parameter int MAXW = 31
) (
  input  logic [MAXW-1:0] state_i,
  input  logic [MAXW-1:0] mask_i,
  input  logic [MAXW-1:0] seed_i,
  input  logic            inv_i,
  output logic [MAXW-1:0] dflt_o,
  output logic [MAXW-1:0] seed_o,
  output logic            lock_o
);

  logic [MAXW-1:0] stuck_val;
  logic [MAXW-1:0] seed_m;

  // XOR locks at zero, XNOR locks at all ones; the default is the opposite.
  assign stuck_val = inv_i ? mask_i : '0;
  assign dflt_o    = inv_i ? '0 : mask_i;
  assign lock_o    = ((state_i & mask_i) == stuck_val);
  assign seed_m    = seed_i & mask_i;
  assign seed_o    = (seed_m == stuck_val) ? dflt_o : seed_m;

endmodule

// File: rtl/prbs_shift_core.sv
module prbs_shift_core
  import prbs_pkg::*;
#(
  parameter int MAXW = PRBS_MAX_STAGES,
  localparam int IW = $clog2(MAXW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic            ld_i,
  input  prbs_mode_e      mode_i,
  input  logic            inv_i,
  input  logic [MAXW-1:0] mask_cur_i,
  input  logic [IW-1:0]   top_cur_i,
  input  logic [MAXW-1:0] mask_new_i,
  input  logic [IW-1:0]   top_new_i,
  input  logic [MAXW-1:0] dflt_cur_i,
  input  logic [MAXW-1:0] seed_ok_i,
  input  logic            lock_i,
  output logic [MAXW-1:0] state_o,
  output prbs_mode_e      cfg_mode_o,
  output logic            cfg_inv_o,
  output logic            bit_o,
  output logic            wrap_o
);

  logic [MAXW-1:0] st_q, st_d, start_q, shifted, dflt_new;
  prbs_mode_e      cfg_mode_q;
  logic            cfg_inv_q, cfg_chg, fb, step;
  logic [IW-1:0]   low_idx;
  logic            bit_q, wrap_q;

  assign cfg_chg  = (mode_i != cfg_mode_q) || (inv_i != cfg_inv_q);
  assign dflt_new = inv_i ? '0 : mask_new_i;
  assign low_idx  = IW'(low_tap_of(cfg_mode_q));
  assign fb       = st_q[top_cur_i] ^ st_q[low_idx] ^ cfg_inv_q;
  assign shifted  = {st_q[MAXW-2:0], fb} & mask_cur_i;

  // Priority: reset / configuration change, seed load, lock-up escape, shift.
  always_comb begin
    st_d = st_q;
    step = 1'b0;
    if (rst || cfg_chg) begin
      st_d = dflt_new;
    end else if (ld_i) begin
      st_d = seed_ok_i;
    end else if (lock_i) begin
      st_d = dflt_cur_i;
    end else if (en_i) begin
      st_d = shifted;
      step = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    st_q       <= st_d;
    cfg_mode_q <= mode_i;
    cfg_inv_q  <= inv_i;
    if (rst || cfg_chg) begin
      start_q <= dflt_new;
    end
    bit_q  <= st_d[top_new_i];
    wrap_q <= step && (shifted == start_q);
  end

  assign state_o    = st_q;
  assign cfg_mode_o = cfg_mode_q;
  assign cfg_inv_o  = cfg_inv_q;
  assign bit_o      = bit_q;
  assign wrap_o     = wrap_q;

endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_pkg::*;
#(
  parameter int MAXW = PRBS_MAX_STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [1:0]      mode,
  input  logic            xnor_fb,
  input  logic            seed_ld,
  input  logic [MAXW-1:0] seed,
  output logic            prbs_bit,
  output logic            wrap
);

  localparam int IW = $clog2(MAXW);

  logic [MAXW-1:0] state_w, mask_cur, mask_new, dflt_cur, seed_ok;
  logic [IW-1:0]   top_cur, top_new;
  prbs_mode_e      cfg_mode_w, mode_e;
  logic            cfg_inv_w, lock_w;

  assign mode_e = prbs_mode_e'(mode);

  prbs_tap_sel #(.MAXW(MAXW)) cur_sel_i (
    .mode_i (cfg_mode_w),
    .mask_o (mask_cur),
    .top_o  (top_cur)
  );

  prbs_tap_sel #(.MAXW(MAXW)) new_sel_i (
    .mode_i (mode_e),
    .mask_o (mask_new),
    .top_o  (top_new)
  );

  prbs_lock_guard #(.MAXW(MAXW)) guard_i (
    .state_i (state_w),
    .mask_i  (mask_cur),
    .seed_i  (seed),
    .inv_i   (cfg_inv_w),
    .dflt_o  (dflt_cur),
    .seed_o  (seed_ok),
    .lock_o  (lock_w)
  );

  prbs_shift_core #(.MAXW(MAXW)) core_i (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en),
    .ld_i       (seed_ld),
    .mode_i     (mode_e),
    .inv_i      (xnor_fb),
    .mask_cur_i (mask_cur),
    .top_cur_i  (top_cur),
    .mask_new_i (mask_new),
    .top_new_i  (top_new),
    .dflt_cur_i (dflt_cur),
    .seed_ok_i  (seed_ok),
    .lock_i     (lock_w),
    .state_o    (state_w),
    .cfg_mode_o (cfg_mode_w),
    .cfg_inv_o  (cfg_inv_w),
    .bit_o      (prbs_bit),
    .wrap_o     (wrap)
  );

endmodule

// File: rtl/prbs_gen_chk.sv
module prbs_gen_chk
  import prbs_pkg::*;
#(
  parameter int MAXW = PRBS_MAX_STAGES
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            seed_ld,
  input logic [1:0]      mode,
  input logic            xnor_fb,
  input logic [MAXW-1:0] seed,
  input logic [MAXW-1:0] st,
  input logic [MAXW-1:0] mask,
  input prbs_mode_e      cfg_mode,
  input logic            cfg_inv,
  input logic            lock,
  input logic            wrap
);

  logic armed_q = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b1;
  end

  logic chg;
  assign chg = (prbs_mode_e'(mode) != cfg_mode) || (xnor_fb != cfg_inv);

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst || !armed_q)
    !chg |-> ((st & mask) != (cfg_inv ? mask : '0))); // R8

  AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (st & ~mask) == '0); // R10

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (en && !seed_ld && !chg && !lock) |=> ((st >> 1) == ($past(st) & ($past(mask) >> 1)))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (!en && !seed_ld && !chg && !lock) |=> ($stable(st) && !wrap)); // R7

  AST_CFG_RESEED: assert property (@(posedge clk) disable iff (rst || !armed_q)
    chg |=> (st == (cfg_inv ? '0 : mask))); // R9

  AST_BAD_SEED: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (seed_ld && !chg && !xnor_fb && ((seed & mask) == '0)) |=> (st == mask)); // R8

  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (rst || !armed_q)
    wrap |=> !wrap); // R4

endmodule

bind prbs_gen prbs_gen_chk #(.MAXW(MAXW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .seed_ld  (seed_ld),
  .mode     (mode),
  .xnor_fb  (xnor_fb),
  .seed     (seed),
  .st       (state_w),
  .mask     (mask_cur),
  .cfg_mode (cfg_mode_w),
  .cfg_inv  (cfg_inv_w),
  .lock     (lock_w),
  .wrap     (wrap)
);

// File: tb/prbs_gen_tb_top.sv
`timescale 1ns/1ps
module prbs_gen_tb_top;

  localparam int W = 31;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1, en = 1'b0, seed_ld = 1'b0, xnor_fb = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [W-1:0] seed = '0;
  logic         prbs_bit, wrap;

  prbs_gen #(.MAXW(W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .xnor_fb(xnor_fb),
    .seed_ld(seed_ld), .seed(seed), .prbs_bit(prbs_bit), .wrap(wrap)
  );

  int n_chk = 0, n_fail = 0;
  bit    q_bit[$];
  bit    q_wrap[$];
  string q_tag[$];
  bit    act_log[$];
  int    wrap_cnt = 0;

  // Reference model state
  logic [W-1:0] m_st = '0, m_start = '0;
  logic [1:0]   m_mode = 2'd0;
  logic         m_inv = 1'b0;

  function automatic int stg(logic [1:0] m);
    case (m) 2'd0: return 5; 2'd1: return 7; 2'd2: return 23; default: return 31; endcase
  endfunction
  function automatic int ltap(logic [1:0] m);
    case (m) 2'd0: return 2; 2'd1: return 5; 2'd2: return 17; default: return 27; endcase
  endfunction
  function automatic logic [W-1:0] msk(logic [1:0] m);
    logic [31:0] t;
    t = (32'h1 << stg(m)) - 32'h1;
    return t[W-1:0];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected outputs.
  task automatic tick(input logic r, input logic e, input logic l,
                      input logic [W-1:0] sv, input logic [1:0] m,
                      input logic p, input string tag);
    logic [W-1:0] mk, dflt, stuck, s;
    logic w;
    @(negedge clk);
    rst = r; en = e; seed_ld = l; seed = sv; mode = m; xnor_fb = p;
    w = 1'b0;
    if (r || m != m_mode || p != m_inv) begin
      mk = msk(m);
      m_st = p ? '0 : mk;
      m_start = m_st;
    end else begin
      mk = msk(m);
      dflt = p ? '0 : mk;
      stuck = p ? mk : '0;
      if (l) begin
        s = sv & mk;
        m_st = (s == stuck) ? dflt : s;
      end else if (m_st == stuck) begin
        m_st = dflt;
      end else if (e) begin
        m_st = {m_st[W-2:0], m_st[stg(m)-1] ^ m_st[ltap(m)] ^ p} & mk;
        w = (m_st == m_start);
      end
    end
    m_mode = m;
    m_inv = p;
    q_bit.push_back(m_st[stg(m)-1]);
    q_wrap.push_back(w);
    q_tag.push_back(tag);
  endtask

  task automatic run(input int n, input logic e, input logic [1:0] m,
                     input logic p, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, e, 1'b0, '0, m, p, tag);
  endtask

  task automatic drain();
    wait (q_bit.size() == 0);
    #1;
  endtask

  // Monitor: pop and compare after each rising edge.
  always @(posedge clk) begin
    #2;
    if (q_bit.size() > 0) begin
      bit eb, ew;
      string t;
      eb = q_bit.pop_front();
      ew = q_wrap.pop_front();
      t  = q_tag.pop_front();
      check({t, " bit"}, 64'(prbs_bit), 64'(eb));
      check({t, " wrap"}, 64'(wrap), 64'(ew));
      act_log.push_back(prbs_bit);
      if (wrap) wrap_cnt++;
    end
  end

  task automatic runs(output int ones, output int zeros);
    int c1, c0;
    ones = 0; zeros = 0; c1 = 0; c0 = 0;
    foreach (act_log[i]) begin
      if (act_log[i]) begin c1++; c0 = 0; end else begin c0++; c1 = 0; end
      if (c1 > ones) ones = c1;
      if (c0 > zeros) zeros = c0;
    end
  endtask

  initial begin
    int o1, z0;
    // R1: reset under XOR, 5 stages
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0, '0, 2'd0, 1'b0, "R1 reset xor");
    drain();
    act_log.delete(); wrap_cnt = 0;
    // R2 R4 R6: two full periods of the 5-stage XOR pattern
    run(62, 1'b1, 2'd0, 1'b0, "R2 len5 xor");
    drain();
    check("R4 len5 wraps in 62 shifts", 64'(wrap_cnt), 64'd2);
    runs(o1, z0);
    check("R6 longest ones run", 64'(o1), 64'd5);
    check("R6 longest zeros run", 64'(z0), 64'd4);
    // R7: idle holds
    run(3, 1'b1, 2'd0, 1'b0, "R2 len5 advance");
    run(6, 1'b0, 2'd0, 1'b0, "R7 idle hold");
    // R9 R3 R4: switch to 7 stages, one full period
    tick(1'b0, 1'b1, 1'b0, '0, 2'd1, 1'b0, "R9 cfg change len7");
    drain(); wrap_cnt = 0;
    run(127, 1'b1, 2'd1, 1'b0, "R3 len7 xor");
    drain();
    check("R4 len7 wraps in 127 shifts", 64'(wrap_cnt), 64'd1);
    // R3: longer polynomials
    tick(1'b0, 1'b1, 1'b0, '0, 2'd2, 1'b0, "R9 cfg change len23");
    run(200, 1'b1, 2'd2, 1'b0, "R3 len23 xor");
    tick(1'b0, 1'b1, 1'b0, '0, 2'd3, 1'b0, "R9 cfg change len31");
    run(200, 1'b1, 2'd3, 1'b0, "R3 len31 xor");
    // R5: XNOR 5 stages, starts from zero, period 31
    tick(1'b0, 1'b1, 1'b0, '0, 2'd0, 1'b1, "R9 cfg change xnor");
    drain(); wrap_cnt = 0;
    run(31, 1'b1, 2'd0, 1'b1, "R5 len5 xnor");
    drain();
    check("R5 xnor wraps in 31 shifts", 64'(wrap_cnt), 64'd1);
    // R5 R8: all-ones seed under XNOR is the lock-up value
    tick(1'b0, 1'b1, 1'b1, 31'h1F, 2'd0, 1'b1, "R5 xnor stuck seed");
    run(8, 1'b1, 2'd0, 1'b1, "R5 after stuck seed");
    // R1: reset mid-run under XNOR
    tick(1'b1, 1'b1, 1'b0, '0, 2'd0, 1'b1, "R1 reset xnor");
    run(4, 1'b1, 2'd0, 1'b1, "R1 after reset xnor");
    // R8: seed loads under XOR
    tick(1'b0, 1'b0, 1'b0, '0, 2'd0, 1'b0, "R9 cfg change to xor");
    tick(1'b0, 1'b1, 1'b1, 31'h0, 2'd0, 1'b0, "R8 zero seed");
    run(5, 1'b1, 2'd0, 1'b0, "R8 after zero seed");
    tick(1'b0, 1'b1, 1'b1, 31'h7FFF_FFE0, 2'd0, 1'b0, "R10 high-only seed");
    run(5, 1'b1, 2'd0, 1'b0, "R10 after high-only seed");
    tick(1'b0, 1'b1, 1'b1, 31'h7FFF_FF0A, 2'd0, 1'b0, "R10 masked seed");
    run(12, 1'b1, 2'd0, 1'b0, "R10 after masked seed");
    tick(1'b0, 1'b0, 1'b1, 31'h13, 2'd0, 1'b0, "R8 load while idle");
    run(3, 1'b0, 2'd0, 1'b0, "R7 hold loaded seed");
    run(6, 1'b1, 2'd0, 1'b0, "R8 run from loaded seed");
    // R9: configuration change beats a seed load
    tick(1'b0, 1'b1, 1'b1, 31'h15, 2'd1, 1'b0, "R9 cfg beats load");
    run(10, 1'b1, 2'd1, 1'b0, "R9 after cfg change");
    drain();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule